// File: doc/BRIEF.md
# Sawtooth-Dithered DAC Requantizer

This block turns a wide unsigned fixed-point command into a narrower DAC code. The low `FRAC_W` bits of the command are a fraction below the DAC code's LSB. A free-running phase counter advances once per update strobe. On each strobe its value `k` is added to the command as the fraction `k / 2^FRAC_W`, and the sum is truncated to the DAC width.

Over one full phase period of `2^FRAC_W` strobes, the output takes the next code up on exactly as many strobes as the command's fraction field counts. The code therefore averages to the command, in the same way a PWM stage averages. The extra resolution equals `FRAC_W` bits and is fixed when the block is built. Within a period the low codes come first and the high codes follow as a single group, because the phase rises monotonically.

A downstream low-pass stage, such as a motor, heater or RC filter, recovers the average.

Top module: `dither_dac_requant`

## Requirements
- R1: Synchronous reset sets `code_o` to 0 and the phase to 0. The first strobe after reset therefore adds a zero fraction.
- R2: On a strobe, the next cycle's `code_o` equals `(cmd_i + k) >> FRAC_W`, where `k` is the number of strobes since reset modulo `2^FRAC_W`. Bits `[FRAC_W-1:0]` of `cmd_i` are the fraction and bits `[CMD_W-1:FRAC_W]` are the integer code.
- R3: When that sum exceeds the largest DAC code, `code_o` is `2^DAC_W-1` instead of wrapping.
- R4: On cycles without a strobe, `code_o` holds its value and the phase does not advance.
- R5: The phase steps by one on each strobe and wraps after `2^FRAC_W` strobes. The codes from one full period, started at phase 0 with a constant non-saturating command, sum to exactly `cmd_i` in units of `2^-FRAC_W`.
- R6: Within one period at a constant command, the codes never decrease. The low codes form one run and the high codes form one run.
- R7: A command whose fraction field is zero gives the integer code on every strobe.
- R8: Every code produced by a strobe equals either the command's integer field or that field plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_i | input | 1 | Update strobe, one sample per asserted cycle |
| cmd_i | input | DAC_W+FRAC_W | Unsigned command, fraction in the low FRAC_W bits |
| code_o | output | DAC_W | Registered DAC code |

## Verification
The properties assume that `cmd_i` is meaningful only in cycles where `upd_i` is high. They also assume that reset is applied synchronously, so the phase count starts from a known edge.

The stimulus changes `cmd_i` only at falling edges. It holds `cmd_i` and `upd_i` for whole cycles and aligns full-period runs to phase 0 before it judges averages or grouping. It mixes back-to-back strobes with idle gaps and uses a mid-period reset, so that the phase tracking of the properties is exercised across both.

// File: rtl/dither_pkg.sv
package dither_pkg;
    // Default geometry shared by the requantizer and its checker
    localparam int DEF_DAC_W  = 8;
    localparam int DEF_FRAC_W = 3;
endpackage

// File: rtl/dither_saw.sv
module dither_saw #(
    parameter int FRAC_W = dither_pkg::DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_i,
    output logic [FRAC_W-1:0] phase_o
);
    typedef struct packed {
        logic [FRAC_W-1:0] phase;
    } saw_state_t;

    saw_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv_i) begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
endmodule

// File: rtl/dither_quant.sv
module dither_quant #(
    parameter int DAC_W  = dither_pkg::DEF_DAC_W,
    parameter int FRAC_W = dither_pkg::DEF_FRAC_W
) (
    input  logic [DAC_W+FRAC_W-1:0] cmd_i,
    input  logic [FRAC_W-1:0]       phase_i,
    output logic [DAC_W-1:0]        code_o
);
    localparam int CMD_W = DAC_W + FRAC_W;
    localparam int PAD_W = CMD_W + 1 - FRAC_W;

    logic [CMD_W:0] sum;
    logic           over;

    always_comb begin
        // Sawtooth sits entirely below the output LSB
        sum    = {1'b0, cmd_i} + {{PAD_W{1'b0}}, phase_i};
        over   = sum[CMD_W];
        code_o = over ? {DAC_W{1'b1}} : sum[CMD_W-1:FRAC_W];
    end
endmodule

// File: rtl/dither_dac_requant.sv
module dither_dac_requant #(
    parameter int DAC_W  = dither_pkg::DEF_DAC_W,
    parameter int FRAC_W = dither_pkg::DEF_FRAC_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    upd_i,
    input  logic [DAC_W+FRAC_W-1:0] cmd_i,
    output logic [DAC_W-1:0]        code_o
);
    typedef struct packed {
        logic [DAC_W-1:0] code;
    } out_state_t;

    logic [FRAC_W-1:0] saw_phase;
    logic [DAC_W-1:0]  quant_code;
    out_state_t        out_d, out_q;

    dither_saw #(.FRAC_W(FRAC_W)) u_saw (
        .clk     (clk),
        .rst     (rst),
        .adv_i   (upd_i),
        .phase_o (saw_phase)
    );

    dither_quant #(.DAC_W(DAC_W), .FRAC_W(FRAC_W)) u_quant (
        .cmd_i   (cmd_i),
        .phase_i (saw_phase),
        .code_o  (quant_code)
    );

    always_comb begin
        out_d = out_q;
        if (upd_i) begin
            out_d.code = quant_code;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign code_o = out_q.code;
endmodule

// File: rtl/dither_dac_requant_chk.sv
module dither_dac_requant_chk #(
    parameter int DAC_W  = dither_pkg::DEF_DAC_W,
    parameter int FRAC_W = dither_pkg::DEF_FRAC_W
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    upd_i,
    input logic [DAC_W+FRAC_W-1:0] cmd_i,
    input logic [DAC_W-1:0]        code_o,
    input logic [FRAC_W-1:0]       phase_w
);
    localparam int CMD_W = DAC_W + FRAC_W;

    logic [DAC_W-1:0]  cmd_int;
    logic [DAC_W:0]    cmd_int_p1;
    logic              frac_zero;
    logic              int_full;
    logic [FRAC_W-1:0] strobe_cnt;

    assign cmd_int    = cmd_i[CMD_W-1:FRAC_W];
    assign cmd_int_p1 = {1'b0, cmd_int} + 1'b1;
    assign frac_zero  = (cmd_i[FRAC_W-1:0] == '0);
    assign int_full   = (cmd_int == {DAC_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_cnt <= '0;
        end else if (upd_i) begin
            strobe_cnt <= strobe_cnt + 1'b1;
        end
    end

    p_reset_r1: assert property (@(posedge clk) rst |=> code_o == '0);

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> $stable(code_o));

    p_phase_r5: assert property (@(posedge clk) disable iff (rst)
        phase_w == strobe_cnt);

    p_range_r8: assert property (@(posedge clk) disable iff (rst)
        upd_i |=> ({1'b0, code_o} == {1'b0, $past(cmd_int)}) ||
                  ({1'b0, code_o} == $past(cmd_int_p1)));

    p_sat_r3: assert property (@(posedge clk) disable iff (rst)
        (upd_i && int_full) |=> code_o == {DAC_W{1'b1}});

    p_zero_frac_r7: assert property (@(posedge clk) disable iff (rst)
        (upd_i && frac_zero) |=> code_o == $past(cmd_int));
endmodule

bind dither_dac_requant dither_dac_requant_chk #(.DAC_W(DAC_W), .FRAC_W(FRAC_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .upd_i   (upd_i),
    .cmd_i   (cmd_i),
    .code_o  (code_o),
    .phase_w (saw_phase)
);

// File: tb/sim_dither_dac_requant.sv
module sim_dither_dac_requant;
    localparam int CLK_PERIOD = 10;
    localparam int DAC_W  = 8;
    localparam int FRAC_W = 3;
    localparam int CMD_W  = DAC_W + FRAC_W;
    localparam int PER    = 1 << FRAC_W;
    localparam int MAXC   = (1 << DAC_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             upd = 1'b0;
    logic [CMD_W-1:0] cmd = '0;
    logic [DAC_W-1:0] code;

    int total = 0;
    int bad   = 0;
    int ph    = 0;
    int exp_q[$];
    string tag_q[$];
    int last8[PER];
    int last_code = 0;
    logic upd_seen = 1'b0;
    logic rst_seen = 1'b0;

    dither_dac_requant #(.DAC_W(DAC_W), .FRAC_W(FRAC_W)) u0 (
        .clk(clk), .rst(rst), .upd_i(upd), .cmd_i(cmd), .code_o(code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic void check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endfunction

    always @(posedge clk) begin
        upd_seen <= upd;
        rst_seen <= rst;
    end

    // Monitor: compares the registered code one half cycle after each edge
    always @(negedge clk) begin
        if (rst_seen) begin
            last_code = 0;
        end else if (upd_seen) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 queue empty", int'(code), -1);
            end else begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(int'(code) == e, t, int'(code), e);
            end
            for (int i = 0; i < PER-1; i++) last8[i] = last8[i+1];
            last8[PER-1] = int'(code);
            last_code = int'(code);
        end else begin
            check(int'(code) == last_code, "R4 hold", int'(code), last_code);
        end
    end

    // Driver: one strobe per call, leaves upd high for the caller to drop
    task automatic strobe(input int c, input string tag);
        int e;
        e = (c + ph) >> FRAC_W;
        if (e > MAXC) e = MAXC;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        ph = (ph + 1) % PER;
        cmd = CMD_W'(c);
        upd = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        upd = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        upd = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        ph = 0;
        @(negedge clk);
    endtask

    task automatic align();
        while (ph != 0) strobe(0, "R2 align");
        idle(1);
    endtask

    task automatic period_check(input int c);
        int s;
        align();
        for (int i = 0; i < PER; i++) strobe(c, "R2 period");
        idle(1);
        s = 0;
        for (int i = 0; i < PER; i++) s += last8[i];
        check(s == c, "R5 period sum", s, c);
        for (int i = 1; i < PER; i++)
            check(last8[i] >= last8[i-1], "R6 grouped runs", last8[i], last8[i-1]);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        check(int'(code) == 0, "R1 reset code", int'(code), 0);

        // 1.625: three strobes at 1, then five at 2
        period_check(13);
        check(last8[0] == 1 && last8[2] == 1 && last8[3] == 2 && last8[7] == 2,
              "R2 1.625 pattern", last8[3], 2);
        period_check(8);     // R7 zero fraction
        for (int i = 0; i < PER; i++)
            check(last8[i] == 1, "R7 constant", last8[i], 1);
        period_check(1);
        period_check(7 * 8 + 7);
        period_check(254 * 8 + 1);

        // R3 saturation at the top of the range
        align();
        for (int i = 0; i < PER; i++) strobe(2047, "R3 saturate");
        idle(1);
        check(last8[7] == MAXC, "R3 top code", last8[7], MAXC);

        // R4 gaps between strobes; phase must not move while idle
        for (int i = 0; i < 12; i++) begin
            strobe(100 + i, "R4 strobe after gap");
            idle(i % 4 + 1);
        end

        // R1 mid-period reset brings phase back to 0
        strobe(21, "R2 pre reset");
        strobe(21, "R2 pre reset");
        strobe(21, "R2 pre reset");
        idle(1);
        do_reset();
        check(int'(code) == 0, "R1 mid reset code", int'(code), 0);
        strobe(15, "R1 first strobe phase 0");
        idle(1);
        check(int'(code) == 1, "R1 phase cleared", int'(code), 1);

        // R8 mixed commands back to back
        for (int i = 0; i < 200; i++) strobe(int'($urandom_range(0, 2047)), "R8 random");
        idle(2);
        check(exp_q.size() == 0, "R2 queue drained", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule